// File: doc/BRIEF.md
# Vectored Interrupt Controller With Daisy-Chain Merge

This block watches a set of level-sensitive interrupt request lines and, every cycle, picks the pending request that matters most. Software programs four things per line through a small memory-mapped register port: a 6-bit level, a register-set number, a non-maskable flag and an enable bit. From the winning line the block builds a descriptor. The descriptor holds a handler address, the level, the register set and the non-maskable flag. It is presented on a valid-qualified output.

The handler address is a programmable base plus the winning line index shifted left by a programmable amount. This places handler entry points at a power-of-two spacing. An optional upstream descriptor input lets several controllers be chained. Each stage forwards whichever of its own winner and the upstream descriptor ranks higher. As a result, the stage nearest the processor presents the overall winner.

Top module: `vic_chain_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and every configuration register reads back as 0, so every line starts disabled.
- R2: The register port stores configuration at these addresses. Address i (i < N_IRQ) holds the config word of line i: level in bits [5:0], register set in bits [8+RS_W-1:8], non-maskable flag in bit 16, enable in bit 17. Address 32 holds the 32-bit vector base. Address 33 holds the shift amount in bits [4:0]. A read returns the stored word on `csr_rdata` one cycle after `csr_read` is sampled high.
- R3: A request on a line whose enable bit is 0 is ignored and never appears in the output descriptor.
- R4: Among enabled maskable requests, the one with the highest level wins.
- R5: An enabled request whose non-maskable flag is set outranks every maskable request, whatever the levels.
- R6: When requests tie on rank (same flag and same level), the lower line index wins.
- R7: The handler address is vector_base + (index << shift), computed modulo 2^32.
- R8: The output carries the winning line's programmed level, register set and non-maskable flag.
- R9: When `up_valid` is high, the upstream descriptor is forwarded unchanged if its rank ({nmi, level}) is greater than or equal to the local winner's rank, or if there is no local winner. Otherwise the local descriptor is forwarded.
- R10: The output is registered and reflects the inputs sampled at the previous clock edge. When there is neither an enabled request nor a valid upstream descriptor, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | N_IRQ | Level-sensitive request lines |
| csr_write | input | 1 | Register write strobe |
| csr_read | input | 1 | Register read strobe |
| csr_addr | input | 6 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| up_valid | input | 1 | Upstream descriptor valid |
| up_addr | input | ADDR_W | Upstream handler address |
| up_level | input | 6 | Upstream level |
| up_regset | input | RS_W | Upstream register set |
| up_nmi | input | 1 | Upstream non-maskable flag |
| out_valid | output | 1 | Descriptor valid |
| out_addr | output | ADDR_W | Handler address |
| out_level | output | 6 | Level of the forwarded request |
| out_regset | output | RS_W | Register set of the forwarded request |
| out_nmi | output | 1 | Non-maskable flag of the forwarded request |

## Verification
The bench aims at the ranking corners:
- A non-maskable line at a low level is raced against a maskable line at a high level. A design that compared levels alone would pick the maskable line.
- Two equal-level lines are raised together. A scan that kept the later match would return the higher index.
- Upstream descriptors are offered that rank above, below and exactly equal to the local winner. A strict comparison would drop the upstream on the tie.
- A masked line with the top level is requested alone and next to a lower enabled line. A design that skipped the enable would report it.
- The vector base and shift are changed. An adder or shifter fault then shows as a wrong handler address.
- The output is also sampled before the capturing edge, which catches a combinational bypass of the output register.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
// Shared widths and the rank function for the vectored interrupt controller.
package vic_pkg;
    localparam int LVL_W = 6;
    localparam int KEY_W = LVL_W + 1;
    localparam int CSR_AW = 6;
    localparam logic [CSR_AW-1:0] SEL_BASE  = 6'd32;
    localparam logic [CSR_AW-1:0] SEL_SHIFT = 6'd33;

    // Rank of a request: non-maskable flag above level.
    function automatic logic [KEY_W-1:0] rank_of(input logic nmi, input logic [LVL_W-1:0] lvl);
        return {nmi, lvl};
    endfunction
endpackage

// File: rtl/vic_cfg_regs.sv
`timescale 1ns/1ps
// Configuration register file: per-line level, register set, flags, plus
// vector base and shift. Assumes N_IRQ <= 32 and RS_W <= 8.
module vic_cfg_regs
    import vic_pkg::*;
#(
    parameter int N_IRQ  = 32,
    parameter int RS_W   = 4,
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_write,
    input  logic                 csr_read,
    input  logic [CSR_AW-1:0]    csr_addr,
    input  logic [31:0]          csr_wdata,
    output logic [31:0]          csr_rdata,
    output logic [LVL_W-1:0]     cfg_lvl [N_IRQ],
    output logic [RS_W-1:0]      cfg_rs  [N_IRQ],
    output logic [N_IRQ-1:0]     cfg_nmi,
    output logic [N_IRQ-1:0]     cfg_en,
    output logic [ADDR_W-1:0]    vec_base,
    output logic [4:0]           vec_shift
);
    localparam int IDX_W = $clog2(N_IRQ);
    localparam logic [CSR_AW-1:0] N_SEL = CSR_AW'(N_IRQ);

    logic [IDX_W-1:0] rd_idx;
    assign rd_idx = csr_addr[IDX_W-1:0];

    // Per-line storage, one copy per request line.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        // Capture a write addressed to this line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_lvl[g] <= '0;
                cfg_rs[g]  <= '0;
                cfg_nmi[g] <= 1'b0;
                cfg_en[g]  <= 1'b0;
            end else if (csr_write && csr_addr == CSR_AW'(g)) begin
                cfg_lvl[g] <= csr_wdata[LVL_W-1:0];
                cfg_rs[g]  <= csr_wdata[8 +: RS_W];
                cfg_nmi[g] <= csr_wdata[16];
                cfg_en[g]  <= csr_wdata[17];
            end
        end
    end

    // Vector base and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base  <= '0;
            vec_shift <= '0;
        end else if (csr_write) begin
            if (csr_addr == SEL_BASE)  vec_base  <= csr_wdata[ADDR_W-1:0];
            if (csr_addr == SEL_SHIFT) vec_shift <= csr_wdata[4:0];
        end
    end

    // Registered read-back mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_rdata <= '0;
        end else if (csr_read) begin
            csr_rdata <= '0;
            if (csr_addr < N_SEL) begin
                csr_rdata[LVL_W-1:0] <= cfg_lvl[rd_idx];
                csr_rdata[8 +: RS_W] <= cfg_rs[rd_idx];
                csr_rdata[16]        <= cfg_nmi[rd_idx];
                csr_rdata[17]        <= cfg_en[rd_idx];
            end else if (csr_addr == SEL_BASE) begin
                csr_rdata[ADDR_W-1:0] <= vec_base;
            end else if (csr_addr == SEL_SHIFT) begin
                csr_rdata[4:0] <= vec_shift;
            end
        end
    end
endmodule

// File: rtl/vic_local_arb.sv
`timescale 1ns/1ps
// Local arbiter: picks the enabled pending line of highest rank; ties go to
// the lowest index. Purely combinational.
module vic_local_arb
    import vic_pkg::*;
#(
    parameter int N_IRQ = 32,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0]  irq_lines,
    input  logic [N_IRQ-1:0]  cfg_en,
    input  logic [N_IRQ-1:0]  cfg_nmi,
    input  logic [LVL_W-1:0]  cfg_lvl [N_IRQ],
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx
);
    logic [KEY_W-1:0] best_key;

    // Scan lines upward; only a strictly higher rank replaces the holder.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_key  = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (irq_lines[i] && cfg_en[i]) begin
                if (!win_valid || rank_of(cfg_nmi[i], cfg_lvl[i]) > best_key) begin
                    win_valid = 1'b1;
                    win_idx   = IDX_W'(i);
                    best_key  = rank_of(cfg_nmi[i], cfg_lvl[i]);
                end
            end
        end
    end
endmodule

// File: rtl/vic_vec_merge.sv
`timescale 1ns/1ps
// Builds the local descriptor (address from base and shifted index) and
// merges it with the upstream descriptor; upstream wins ties.
module vic_vec_merge
    import vic_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int RS_W   = 4,
    parameter int ADDR_W = 32
) (
    input  logic              loc_valid,
    input  logic [IDX_W-1:0]  loc_idx,
    input  logic [LVL_W-1:0]  loc_lvl,
    input  logic [RS_W-1:0]   loc_rs,
    input  logic              loc_nmi,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic [4:0]        vec_shift,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [LVL_W-1:0]  up_level,
    input  logic [RS_W-1:0]   up_regset,
    input  logic              up_nmi,
    output logic              nx_valid,
    output logic [ADDR_W-1:0] nx_addr,
    output logic [LVL_W-1:0]  nx_level,
    output logic [RS_W-1:0]   nx_regset,
    output logic              nx_nmi
);
    logic [ADDR_W-1:0] loc_addr;
    logic              take_up;

    // Handler address of the local winner.
    always_comb begin
        loc_addr = vec_base + ({{(ADDR_W-IDX_W){1'b0}}, loc_idx} << vec_shift);
    end

    // Choose the forwarded descriptor.
    always_comb begin
        take_up = up_valid &&
                  (!loc_valid || rank_of(up_nmi, up_level) >= rank_of(loc_nmi, loc_lvl));
        nx_valid  = up_valid || loc_valid;
        nx_addr   = take_up ? up_addr   : loc_addr;
        nx_level  = take_up ? up_level  : loc_lvl;
        nx_regset = take_up ? up_regset : loc_rs;
        nx_nmi    = take_up ? up_nmi    : loc_nmi;
        if (!nx_valid) begin
            nx_addr   = '0;
            nx_level  = '0;
            nx_regset = '0;
            nx_nmi    = 1'b0;
        end
    end
endmodule

// File: rtl/vic_chain_top.sv
`timescale 1ns/1ps
// Vectored interrupt controller stage. Registers the winning descriptor one
// cycle after its inputs. HAS_UPSTREAM=0 removes the chain input.
module vic_chain_top
    import vic_pkg::*;
#(
    parameter int N_IRQ        = 32,
    parameter int RS_W         = 4,
    parameter int ADDR_W       = 32,
    parameter bit HAS_UPSTREAM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_lines,
    input  logic              csr_write,
    input  logic              csr_read,
    input  logic [5:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [5:0]        up_level,
    input  logic [RS_W-1:0]   up_regset,
    input  logic              up_nmi,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [5:0]        out_level,
    output logic [RS_W-1:0]   out_regset,
    output logic              out_nmi
);
    localparam int IDX_W = $clog2(N_IRQ);

    logic [LVL_W-1:0]  cfg_lvl [N_IRQ];
    logic [RS_W-1:0]   cfg_rs  [N_IRQ];
    logic [N_IRQ-1:0]  cfg_nmi, cfg_en;
    logic [ADDR_W-1:0] vec_base;
    logic [4:0]        vec_shift;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic              up_v_int;
    logic              nx_valid, nx_nmi;
    logic [ADDR_W-1:0] nx_addr;
    logic [LVL_W-1:0]  nx_level;
    logic [RS_W-1:0]   nx_regset;

    vic_cfg_regs #(.N_IRQ(N_IRQ), .RS_W(RS_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .csr_write(csr_write), .csr_read(csr_read),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cfg_lvl(cfg_lvl), .cfg_rs(cfg_rs), .cfg_nmi(cfg_nmi), .cfg_en(cfg_en),
        .vec_base(vec_base), .vec_shift(vec_shift)
    );

    vic_local_arb #(.N_IRQ(N_IRQ)) u_arb (
        .irq_lines(irq_lines), .cfg_en(cfg_en), .cfg_nmi(cfg_nmi),
        .cfg_lvl(cfg_lvl), .win_valid(win_valid), .win_idx(win_idx)
    );

    // Chain input present or tied off.
    if (HAS_UPSTREAM) begin : g_up
        assign up_v_int = up_valid;
    end else begin : g_no_up
        assign up_v_int = 1'b0;
    end

    vic_vec_merge #(.IDX_W(IDX_W), .RS_W(RS_W), .ADDR_W(ADDR_W)) u_merge (
        .loc_valid(win_valid), .loc_idx(win_idx), .loc_lvl(cfg_lvl[win_idx]),
        .loc_rs(cfg_rs[win_idx]), .loc_nmi(cfg_nmi[win_idx]),
        .vec_base(vec_base), .vec_shift(vec_shift),
        .up_valid(up_v_int), .up_addr(up_addr), .up_level(up_level),
        .up_regset(up_regset), .up_nmi(up_nmi),
        .nx_valid(nx_valid), .nx_addr(nx_addr), .nx_level(nx_level),
        .nx_regset(nx_regset), .nx_nmi(nx_nmi)
    );

    // Output descriptor register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            out_level  <= '0;
            out_regset <= '0;
            out_nmi    <= 1'b0;
        end else begin
            out_valid  <= nx_valid;
            out_addr   <= nx_addr;
            out_level  <= nx_level;
            out_regset <= nx_regset;
            out_nmi    <= nx_nmi;
        end
    end
endmodule

// File: rtl/vic_chain_chk.sv
`timescale 1ns/1ps
// Port-level temporal checks for vic_chain_top.
module vic_chain_chk #(
    parameter int N_IRQ  = 32,
    parameter int RS_W   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_IRQ-1:0]  irq_lines,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_addr,
    input logic [5:0]        up_level,
    input logic [RS_W-1:0]   up_regset,
    input logic              up_nmi,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_nmi
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid && irq_lines == '0) |=> !out_valid);

    // R9
    up_forward_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> out_valid);

    // R5
    up_nmi_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_nmi) |=> out_nmi);

    // R9
    up_top_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_nmi && up_level == 6'd63) |=> (out_addr == $past(up_addr)));
endmodule

bind vic_chain_top vic_chain_chk #(.N_IRQ(N_IRQ), .RS_W(RS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .up_valid(up_valid),
    .up_addr(up_addr), .up_level(up_level), .up_regset(up_regset), .up_nmi(up_nmi),
    .out_valid(out_valid), .out_addr(out_addr), .out_nmi(out_nmi)
);

// File: tb/vic_chain_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected descriptors, a monitor pops
// and compares them just after the capturing clock edge.
module vic_chain_top_tb;
    localparam int N = 32;
    localparam int RS_W = 4;

    typedef struct {
        logic        v;
        logic [31:0] a;
        logic [5:0]  l;
        logic [3:0]  r;
        logic        n;
        string       tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] irq_lines = '0;
    logic csr_write = 0, csr_read = 0;
    logic [5:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0, csr_rdata;
    logic up_valid = 0, up_nmi = 0;
    logic [31:0] up_addr = '0;
    logic [5:0] up_level = '0;
    logic [3:0] up_regset = '0;
    logic out_valid, out_nmi;
    logic [31:0] out_addr;
    logic [5:0] out_level;
    logic [3:0] out_regset;

    int checks = 0, errors = 0;
    exp_t q[$];

    // bench model of the configuration
    logic [5:0] m_lvl [N];
    logic [3:0] m_rs  [N];
    logic       m_nmi [N];
    logic       m_en  [N];
    logic [31:0] m_base = 0;
    logic [4:0]  m_shift = 0;

    always #10 clk = ~clk;

    vic_chain_top #(.N_IRQ(N), .RS_W(RS_W), .ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .csr_write(csr_write), .csr_read(csr_read), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .up_valid(up_valid), .up_addr(up_addr), .up_level(up_level),
        .up_regset(up_regset), .up_nmi(up_nmi),
        .out_valid(out_valid), .out_addr(out_addr), .out_level(out_level),
        .out_regset(out_regset), .out_nmi(out_nmi)
    );

    function automatic logic [31:0] word(input logic en, input logic nmi,
                                         input logic [3:0] rs, input logic [5:0] lvl);
        return {14'd0, en, nmi, 4'd0, rs, 2'd0, lvl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_write = 1; csr_addr = a; csr_wdata = d;
        if (a < 6'd32) begin
            m_lvl[a] = d[5:0]; m_rs[a] = d[11:8]; m_nmi[a] = d[16]; m_en[a] = d[17];
        end else if (a == 6'd32) m_base = d;
        else if (a == 6'd33) m_shift = d[4:0];
        @(negedge clk);
        csr_write = 0;
    endtask

    task automatic csr_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        csr_read = 1; csr_addr = a;
        @(posedge clk); #2;
        check(req, csr_rdata, exp);
        @(negedge clk);
        csr_read = 0;
    endtask

    // driver: apply stimulus, compute expected descriptor from the rules
    task automatic apply(input string tag, input logic [N-1:0] irq,
                         input logic uv, input logic [31:0] ua, input logic [5:0] ul,
                         input logic [3:0] ur, input logic un);
        exp_t e;
        logic lv;
        int li;
        logic [6:0] lk;
        @(negedge clk);
        irq_lines = irq; up_valid = uv; up_addr = ua; up_level = ul;
        up_regset = ur; up_nmi = un;
        lv = 0; li = 0; lk = 0;
        for (int i = 0; i < N; i++)
            if (irq[i] && m_en[i] && (!lv || {m_nmi[i], m_lvl[i]} > lk)) begin
                lv = 1; li = i; lk = {m_nmi[i], m_lvl[i]};
            end
        e.tag = tag;
        if (uv && (!lv || {un, ul} >= lk)) begin
            e.v = 1; e.a = ua; e.l = ul; e.r = ur; e.n = un;
        end else if (lv) begin
            e.v = 1; e.a = m_base + (32'(li) << m_shift);
            e.l = m_lvl[li]; e.r = m_rs[li]; e.n = m_nmi[li];
        end else begin
            e.v = 0; e.a = 0; e.l = 0; e.r = 0; e.n = 0;
        end
        q.push_back(e);
    endtask

    // monitor: compare one expected item per clock edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " valid"}, 32'(out_valid), 32'(e.v));
            if (e.v) begin
                check({e.tag, " addr"}, out_addr, e.a);
                check({e.tag, " level (R8)"}, 32'(out_level), 32'(e.l));
                check({e.tag, " regset (R8)"}, 32'(out_regset), 32'(e.r));
                check({e.tag, " nmi (R8)"}, 32'(out_nmi), 32'(e.n));
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_lvl[i] = 0; m_rs[i] = 0; m_nmi[i] = 0; m_en[i] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        check("R1 out_valid after reset", 32'(out_valid), 0);
        @(negedge clk);
        rst_n = 1;
        csr_rd("R1 line 5 cleared", 6'd5, 0);
        csr_rd("R1 base cleared", 6'd32, 0);

        csr_wr(6'd32, 32'h0000_1000);
        csr_wr(6'd33, 32'd4);
        csr_wr(6'd3,  word(1, 0, 4'd2, 6'd10));
        csr_wr(6'd7,  word(1, 0, 4'd5, 6'd20));
        csr_wr(6'd9,  word(1, 0, 4'd1, 6'd20));
        csr_wr(6'd12, word(1, 1, 4'd7, 6'd5));
        csr_wr(6'd15, word(0, 0, 4'd6, 6'd63));
        csr_wr(6'd31, word(1, 0, 4'd3, 6'd1));
        csr_rd("R2 line 3 word", 6'd3, word(1, 0, 4'd2, 6'd10));
        csr_rd("R2 line 12 word", 6'd12, word(1, 1, 4'd7, 6'd5));
        csr_rd("R2 base", 6'd32, 32'h0000_1000);
        csr_rd("R2 shift", 6'd33, 32'd4);

        apply("R3 disabled alone", 32'h1 << 15, 0, 0, 0, 0, 0);
        apply("R3 disabled next to low line", (32'h1 << 15) | (32'h1 << 31), 0, 0, 0, 0, 0);
        apply("R4 R7 level 10 over 1", (32'h1 << 3) | (32'h1 << 31), 0, 0, 0, 0, 0);
        apply("R4 level 20 over 10", (32'h1 << 3) | (32'h1 << 7), 0, 0, 0, 0, 0);
        apply("R6 tie lower index", (32'h1 << 7) | (32'h1 << 9), 0, 0, 0, 0, 0);
        apply("R5 nmi low level wins", (32'h1 << 7) | (32'h1 << 12), 0, 0, 0, 0, 0);

        // one-cycle latency: output must not move before the edge
        apply("R10 idle", 32'h0, 0, 0, 0, 0, 0);
        @(negedge clk);
        irq_lines = 32'h1 << 3;
        #1;
        check("R10 no change before edge", 32'(out_valid), 0);
        @(posedge clk); #2;
        check("R10 updated after edge", 32'(out_valid), 1);
        check("R7 address line 3", out_addr, 32'h0000_1030);

        csr_wr(6'd32, 32'h8000_0000);
        csr_wr(6'd33, 32'd8);
        apply("R7 new base and shift", 32'h1 << 31, 0, 0, 0, 0, 0);

        apply("R9 upstream higher", 32'h1 << 7, 1, 32'hCAFE_0000, 6'd30, 4'd9, 0);
        apply("R9 upstream lower", 32'h1 << 7, 1, 32'hCAFE_0000, 6'd15, 4'd9, 0);
        apply("R9 upstream tie wins", 32'h1 << 7, 1, 32'hBEEF_0000, 6'd20, 4'd8, 0);
        apply("R9 upstream nmi lower", 32'h1 << 12, 1, 32'hABCD_0000, 6'd0, 4'd2, 1);
        apply("R9 upstream alone", 32'h0, 1, 32'h1234_5678, 6'd3, 4'd4, 0);
        apply("R10 nothing pending", 32'h0, 0, 0, 0, 0, 0);

        repeat (3) @(posedge clk);
        #5;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule